// File: doc/BRIEF.md
# Data Cache Maintenance Unit

This block executes maintenance commands against a small two-way, write-back data cache model that it owns. Each line holds a valid bit, a dirty bit, a line address and one data word. A command carries a 4-bit register selector, a 3-bit sub-opcode and a 32-bit operand. The supported commands are: clean one entry, clean and invalidate one entry, clean the whole cache, invalidate the whole cache, prefetch a line by address, drain the write buffer and wait for an interrupt. Dirty lines leave the block through a request/acknowledge write-back port.

Single-entry commands locate their line through way and index fields in the operand. The bit positions of those fields are not fixed. They are worked out on every command from a geometry word, so one netlist serves several line sizes and cache sizes. A store port is the cache model's write path. It lets the surrounding logic, or a bench, install dirty lines while the unit is idle. A mode input makes a single clean-entry command clean the addressed index in every way.

Top module: `dcm_unit`

## Requirements
- R1: After reset, busy, done and wb_req are low and every line is invalid, so a clean-all issues no write-back.
- R2: With geometry word G, the way field is operand[31:x] with x = 32 − G[17:15] − G[14]. The index field is operand[y:z] with y = 8 + G[20:18] − G[17:15] and z = G[13:12] + 3. Operand bits below z are ignored. Store and prefetch addresses use the same index bits, and their line address is the address with bits below z cleared.
- R3: Clean entry (selector 1010, sub-opcode 010) on a valid dirty line raises wb_req with that line's address and data. wb_req holds until wb_ack, after which the line is clean and still valid. On a clean or invalid line, done is high in the second cycle after accept and no write-back occurs.
- R4: When cfg_clean_both is high, one clean-entry command cleans the addressed index in way 0 and then way 1, and operand bit 31 has no effect. When cfg_clean_both is low, only the way named by the operand is cleaned.
- R5: Clean-and-invalidate entry (selector 1110, sub-opcode 010) writes back the selected line if it is dirty, then leaves it invalid.
- R6: Clean all (selector 1010, sub-opcode 000) visits index 0 upward, and at each index way 0 then way 1. Write-backs appear in that order. With no dirty line, done is high in cycle SETS×WAYS+1 after accept.
- R7: Invalidate all (selector 0110, sub-opcode 000) invalidates every line and discards dirty data with no write-back. Done is high in the second cycle after accept.
- R8: Prefetch (selector 1101, sub-opcode 001) does nothing on a hit. On a miss it fills the lowest invalid way, or way 0 if every way is valid, as a clean line. A dirty victim is written back first.
- R9: Drain write buffer (selector 1010, sub-opcode 100) keeps busy high, with done low, until wbuf_empty is high.
- R10: Wait for interrupt (selector 0000, sub-opcode 100) keeps busy high, with done low, until irq is high.
- R11: busy is high from the accept edge until the done cycle ends. Commands and stores presented while busy are ignored, and done never appears without busy.
- R12: Any other selector and sub-opcode pair is accepted with done in the first cycle after accept, and the cache is left unchanged.
- R13: When the unit is idle, a store writes its line as valid and dirty. A store and a command presented in the same cycle are both taken, and the command sees the stored line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_crm | input | 4 | Register selector |
| cmd_op2 | input | 3 | Sub-opcode |
| cmd_rd | input | 32 | Operand (way/index or address) |
| cfg_geom | input | 32 | Cache geometry word |
| cfg_clean_both | input | 1 | Clean-entry acts on all ways |
| st_en | input | 1 | Store into the cache model |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_way | input | WAY_W | Way written by the store |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completes this cycle |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 32 | Write-back line address |
| wb_data | output | 32 | Write-back data |
| wb_ack | input | 1 | Write-back accepted |
| wbuf_empty | input | 1 | External write buffer empty |
| irq | input | 1 | Interrupt pending |

## Verification
Two functions can meet in one cycle: the idle unit accepts a store and a command on the same edge. The bench drives a store to index 14 and a clean-entry for that same index on the same negedge. It then requires a write-back carrying exactly the stored address and data, which shows that the maintenance walk reads the array only after the store has landed. The opposite case is a store or command arriving while the unit is busy. The bench judges this by a later clean-all whose write-back list must not contain the ignored line.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAN_ENT,
        OP_CLINV_ENT,
        OP_CLEAN_ALL,
        OP_INV_ALL,
        OP_PREFETCH,
        OP_DRAIN,
        OP_WFI
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WB,
        ST_PF,
        ST_INVALL,
        ST_WAIT_IRQ,
        ST_WAIT_DRAIN,
        ST_FIN
    } st_e;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } line_t;

endpackage

// File: rtl/dcm_decode.sv
module dcm_decode
    import dcm_pkg::*;
(
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output op_e        op
);
    always_comb begin
        unique case ({crm, op2})
            {4'b1010, 3'b010}: op = OP_CLEAN_ENT;
            {4'b1110, 3'b010}: op = OP_CLINV_ENT;
            {4'b1010, 3'b000}: op = OP_CLEAN_ALL;
            {4'b0110, 3'b000}: op = OP_INV_ALL;
            {4'b1101, 3'b001}: op = OP_PREFETCH;
            {4'b0000, 3'b100}: op = OP_WFI;
            {4'b1010, 3'b100}: op = OP_DRAIN;
            default:           op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/dcm_geom.sv
module dcm_geom #(
    parameter int IDX_W = 4,
    parameter int WAY_W = 1
) (
    input  logic [31:0]      geom,
    input  logic [31:0]      operand,
    output logic [IDX_W-1:0] idx,
    output logic [WAY_W-1:0] way,
    output logic [31:0]      line_addr
);
    logic [6:0]  x_pos, y_pos, z_pos;
    logic [31:0] idx_mask, idx_full, way_full;
    logic        unused_bits;

    always_comb begin
        x_pos = 7'd32 - {4'd0, geom[17:15]} - {6'd0, geom[14]};
        y_pos = 7'd8 + {4'd0, geom[20:18]} - {4'd0, geom[17:15]};
        z_pos = {5'd0, geom[13:12]} + 7'd3;
        if (y_pos >= z_pos)
            idx_mask = (32'd1 << (y_pos - z_pos + 7'd1)) - 32'd1;
        else
            idx_mask = 32'd0;
        idx_full  = (operand >> z_pos) & idx_mask;
        way_full  = operand >> x_pos;
        idx       = idx_full[IDX_W-1:0];
        way       = way_full[WAY_W-1:0];
        line_addr = operand & ~((32'd1 << z_pos) - 32'd1);
    end

    assign unused_bits = ^{idx_full, way_full, geom[31:21], geom[11:0]};
endmodule

// File: rtl/dcm_array.sv
module dcm_array
    import dcm_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output line_t [WAYS-1:0]     rd_lines,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [WAY_W-1:0]     wr_way,
    input  line_t                wr_line,
    input  logic                 clr_all
);
    line_t mem_q [SETS][WAYS];
    line_t mem_d [SETS][WAYS];
    logic [SETS*WAYS-1:0] valid_vec;

    always_comb begin
        mem_d = mem_q;
        if (clr_all) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    mem_d[s][w].valid = 1'b0;
                    mem_d[s][w].dirty = 1'b0;
                end
        end else if (wr_en) begin
            mem_d[wr_idx][wr_way] = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    mem_q[s][w] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_rd
            assign rd_lines[g] = mem_q[rd_idx][g];
        end
    endgenerate

    always_comb begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                valid_vec[s*WAYS+w] = mem_q[s][w].valid;
    end

    assert_inval_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> ($countones(valid_vec) == 0));
endmodule

// File: rtl/dcm_unit.sv
module dcm_unit
    import dcm_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_crm,
    input  logic [2:0]       cmd_op2,
    input  logic [31:0]      cmd_rd,
    input  logic [31:0]      cfg_geom,
    input  logic             cfg_clean_both,
    input  logic             st_en,
    input  logic [31:0]      st_addr,
    input  logic [31:0]      st_data,
    input  logic [WAY_W-1:0] st_way,
    output logic             busy,
    output logic             done,
    output logic             wb_req,
    output logic [31:0]      wb_addr,
    output logic [31:0]      wb_data,
    input  logic             wb_ack,
    input  logic             wbuf_empty,
    input  logic             irq
);
    typedef struct packed {
        st_e              st;
        op_e              op;
        logic [IDX_W-1:0] idx;
        logic [WAY_W-1:0] way;
        logic             all_ways;
        logic             inval;
        logic [31:0]      pf_addr;
    } regs_t;

    regs_t r_q, r_d;

    op_e              dec_op;
    logic [IDX_W-1:0] c_idx, s_idx;
    logic [WAY_W-1:0] c_way, s_way_unused;
    logic [31:0]      c_line, s_line;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [WAY_W-1:0] wr_way;
    line_t [WAYS-1:0] rd_lines;
    line_t            wr_line, cur;
    logic             wr_en, clr_all;

    st_e              adv_st;
    logic [IDX_W-1:0] adv_idx;
    logic [WAY_W-1:0] adv_way;
    logic             pf_hit;
    logic [WAY_W-1:0] victim;

    dcm_decode u_dec (.crm(cmd_crm), .op2(cmd_op2), .op(dec_op));

    dcm_geom #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_cmd_geom (
        .geom(cfg_geom), .operand(cmd_rd),
        .idx(c_idx), .way(c_way), .line_addr(c_line));

    dcm_geom #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_st_geom (
        .geom(cfg_geom), .operand(st_addr),
        .idx(s_idx), .way(s_way_unused), .line_addr(s_line));

    dcm_array #(.SETS(SETS), .WAYS(WAYS)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_lines(rd_lines),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way), .wr_line(wr_line),
        .clr_all(clr_all));

    assign rd_idx = r_q.idx;
    assign cur    = rd_lines[r_q.way];

    // step to the next line of a walk, or finish
    always_comb begin
        adv_st  = ST_FIN;
        adv_idx = r_q.idx;
        adv_way = r_q.way;
        if (r_q.all_ways && (r_q.way != WAY_W'(WAYS - 1))) begin
            adv_way = r_q.way + WAY_W'(1);
            adv_st  = ST_SCAN;
        end else if ((r_q.op == OP_CLEAN_ALL) && (r_q.idx != IDX_W'(SETS - 1))) begin
            adv_idx = r_q.idx + IDX_W'(1);
            adv_way = '0;
            adv_st  = ST_SCAN;
        end
    end

    // prefetch lookup: hit detection and victim choice
    always_comb begin
        pf_hit = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++)
            if (rd_lines[w].valid && (rd_lines[w].addr == r_q.pf_addr))
                pf_hit = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!rd_lines[w].valid)
                victim = WAY_W'(w);
    end

    always_comb begin
        r_d     = r_q;
        wr_en   = 1'b0;
        wr_idx  = r_q.idx;
        wr_way  = r_q.way;
        wr_line = '0;
        clr_all = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (st_en) begin
                    wr_en   = 1'b1;
                    wr_idx  = s_idx;
                    wr_way  = st_way;
                    wr_line = '{valid: 1'b1, dirty: 1'b1, addr: s_line, data: st_data};
                end
                if (cmd_valid) begin
                    r_d.op       = dec_op;
                    r_d.idx      = c_idx;
                    r_d.way      = c_way;
                    r_d.all_ways = 1'b0;
                    r_d.inval    = 1'b0;
                    r_d.pf_addr  = c_line;
                    unique case (dec_op)
                        OP_CLEAN_ENT: begin
                            if (cfg_clean_both) begin
                                r_d.way      = '0;
                                r_d.all_ways = 1'b1;
                            end
                            r_d.st = ST_SCAN;
                        end
                        OP_CLINV_ENT: begin
                            r_d.inval = 1'b1;
                            r_d.st    = ST_SCAN;
                        end
                        OP_CLEAN_ALL: begin
                            r_d.idx      = '0;
                            r_d.way      = '0;
                            r_d.all_ways = 1'b1;
                            r_d.st       = ST_SCAN;
                        end
                        OP_INV_ALL:  r_d.st = ST_INVALL;
                        OP_PREFETCH: r_d.st = ST_PF;
                        OP_DRAIN:    r_d.st = ST_WAIT_DRAIN;
                        OP_WFI:      r_d.st = ST_WAIT_IRQ;
                        default:     r_d.st = ST_FIN;
                    endcase
                end
            end
            ST_SCAN: begin
                if (cur.valid && cur.dirty) begin
                    r_d.st = ST_WB;
                end else begin
                    if (r_q.inval) begin
                        wr_en         = 1'b1;
                        wr_line       = cur;
                        wr_line.valid = 1'b0;
                        wr_line.dirty = 1'b0;
                    end
                    r_d.st  = adv_st;
                    r_d.idx = adv_idx;
                    r_d.way = adv_way;
                end
            end
            ST_WB: begin
                if (wb_ack) begin
                    wr_en = 1'b1;
                    if (r_q.op == OP_PREFETCH) begin
                        wr_line = '{valid: 1'b1, dirty: 1'b0, addr: r_q.pf_addr, data: '0};
                        r_d.st  = ST_FIN;
                    end else begin
                        wr_line       = cur;
                        wr_line.dirty = 1'b0;
                        wr_line.valid = ~r_q.inval;
                        r_d.st  = adv_st;
                        r_d.idx = adv_idx;
                        r_d.way = adv_way;
                    end
                end
            end
            ST_PF: begin
                if (pf_hit) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.way = victim;
                    if (rd_lines[victim].valid && rd_lines[victim].dirty) begin
                        r_d.st = ST_WB;
                    end else begin
                        wr_en   = 1'b1;
                        wr_way  = victim;
                        wr_line = '{valid: 1'b1, dirty: 1'b0, addr: r_q.pf_addr, data: '0};
                        r_d.st  = ST_FIN;
                    end
                end
            end
            ST_INVALL: begin
                clr_all = 1'b1;
                r_d.st  = ST_FIN;
            end
            ST_WAIT_DRAIN: if (wbuf_empty) r_d.st = ST_FIN;
            ST_WAIT_IRQ:   if (irq)        r_d.st = ST_FIN;
            default:       r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.op <= OP_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = (r_q.st == ST_FIN);
    assign wb_req  = (r_q.st == ST_WB);
    assign wb_addr = cur.addr;
    assign wb_data = cur.data;

    logic unused_way;
    assign unused_way = ^s_way_unused;

    assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_idle_no_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wb_req);
    assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
    assert_wb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_data)));
    assert_drain_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_DRAIN && !wbuf_empty) |=> (busy && !done));
    assert_irq_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_IRQ && !irq) |=> (busy && !done));
endmodule

// File: tb/dcm_unit_bench.sv
`timescale 1ns/1ps
module dcm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_crm = '0;
    logic [2:0]  cmd_op2 = '0;
    logic [31:0] cmd_rd = '0;
    logic [31:0] cfg_geom = 32'h0000_9000;
    logic        cfg_clean_both = 1'b0;
    logic        st_en = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [0:0]  st_way = '0;
    logic        busy, done, wb_req;
    logic [31:0] wb_addr, wb_data;
    logic        wb_ack = 1'b0;
    logic        wbuf_empty = 1'b1;
    logic        irq = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [63:0] exp_q[$];

    localparam logic [31:0] G1 = 32'h0000_9000; // x=31, y=7, z=4
    localparam logic [31:0] G2 = 32'h0004_A000; // x=31, y=8, z=5

    always #2 clk = ~clk;

    dcm_unit u_dcm_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_crm(cmd_crm),
        .cmd_op2(cmd_op2), .cmd_rd(cmd_rd), .cfg_geom(cfg_geom),
        .cfg_clean_both(cfg_clean_both), .st_en(st_en), .st_addr(st_addr),
        .st_data(st_data), .st_way(st_way), .busy(busy), .done(done),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack),
        .wbuf_empty(wbuf_empty), .irq(irq));

    function automatic logic [31:0] la(input int tag, input int idx);
        return (32'(tag) << 8) | (32'(idx) << 4);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_wb(input logic [31:0] a, input logic [31:0] d);
        exp_q.push_back({a, d});
    endtask

    // monitor: acknowledges write-backs after two cycles and scores them
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (wb_ack) begin
                wb_ack = 1'b0;
            end else if (wb_req) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    wait_cnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3/R7", "unexpected write-back addr", wb_addr, 32'h0);
                    end else begin
                        logic [63:0] e;
                        e = exp_q.pop_front();
                        chk(wb_addr == e[63:32], "R3", "write-back address", wb_addr, e[63:32]);
                        chk(wb_data == e[31:0], "R3", "write-back data", wb_data, e[31:0]);
                    end
                    wb_ack = 1'b1;
                end
            end
        end
    end

    task automatic send(input logic [3:0] c, input logic [2:0] o, input logic [31:0] rd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_crm = c; cmd_op2 = o; cmd_rd = rd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [2:0] o, input logic [31:0] rd,
                         output int n);
        send(c, o, rd);
        wait_done(n);
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        st_en = 1'b1; st_addr = a; st_data = d; st_way = w;
        @(negedge clk);
        st_en = 1'b0;
    endtask

    task automatic q_empty(input string req);
        chk(exp_q.size() == 0, req, "missing write-backs", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic clean_all(input string req);
        int n;
        issue(4'b1010, 3'b000, 32'h0, n);
        q_empty(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy, "R1", "busy after reset", 32'(busy), 0);
        chk(!done, "R1", "done after reset", 32'(done), 0);
        chk(!wb_req, "R1", "wb_req after reset", 32'(wb_req), 0);
        issue(4'b1010, 3'b000, 32'h0, n);
        chk(n == 33, "R6", "empty clean-all cycles", 32'(n), 33);
        q_empty("R1");

        // R3 clean entry
        store(la(1, 2), 32'hA1A1_0001, 1'b0);
        expect_wb(la(1, 2), 32'hA1A1_0001);
        issue(4'b1010, 3'b010, 32'(2 << 4), n);
        q_empty("R3");
        issue(4'b1010, 3'b010, 32'(2 << 4), n);
        chk(n == 2, "R3", "clean line done cycle", 32'(n), 2);
        q_empty("R3");

        // R5 clean and invalidate entry
        store(la(2, 3), 32'hB1B1_0002, 1'b1);
        store(la(3, 3), 32'hC1C1_0003, 1'b0);
        expect_wb(la(2, 3), 32'hB1B1_0002);
        issue(4'b1110, 3'b010, 32'h8000_0000 | 32'(3 << 4), n);
        q_empty("R5");
        issue(4'b1101, 3'b001, la(4, 3), n);   // fills the freed way 1
        q_empty("R5");
        expect_wb(la(3, 3), 32'hC1C1_0003);
        clean_all("R5");

        // R6 clean-all order
        store(la(5, 9), 32'hD9D9_0009, 1'b0);
        store(la(6, 3), 32'hE3E3_0003, 1'b1);
        store(la(7, 1), 32'hF1F1_0001, 1'b1);
        store(la(8, 3), 32'h6363_0003, 1'b0);
        expect_wb(la(7, 1), 32'hF1F1_0001);
        expect_wb(la(8, 3), 32'h6363_0003);
        expect_wb(la(6, 3), 32'hE3E3_0003);
        expect_wb(la(5, 9), 32'hD9D9_0009);
        clean_all("R6");

        // R4 both-ways mode, operand bit 31 don't-care
        cfg_clean_both = 1'b1;
        store(la(9, 5), 32'h0505_0000, 1'b0);
        store(la(10, 5), 32'h0505_0001, 1'b1);
        expect_wb(la(9, 5), 32'h0505_0000);
        expect_wb(la(10, 5), 32'h0505_0001);
        issue(4'b1010, 3'b010, 32'h8000_0000 | 32'(5 << 4), n);
        q_empty("R4");
        cfg_clean_both = 1'b0;
        store(la(11, 5), 32'h1111_0005, 1'b1);
        store(la(12, 5), 32'h1212_0005, 1'b0);
        expect_wb(la(11, 5), 32'h1111_0005);
        issue(4'b1010, 3'b010, 32'h8000_0000 | 32'(5 << 4), n);
        q_empty("R4");
        expect_wb(la(12, 5), 32'h1212_0005);
        clean_all("R4");

        // R7 invalidate all discards dirty data
        store(la(13, 7), 32'h7777_0007, 1'b0);
        store(la(14, 8), 32'h8888_0008, 1'b1);
        issue(4'b0110, 3'b000, 32'h0, n);
        chk(n == 2, "R7", "invalidate-all done cycle", 32'(n), 2);
        clean_all("R7");

        // R8 prefetch
        issue(4'b1101, 3'b001, la(6, 5) | 32'h8, n);
        q_empty("R8");
        store(la(7, 5), 32'h7575_0000, 1'b1);
        issue(4'b1101, 3'b001, la(6, 5) | 32'h4, n);
        chk(n == 2, "R8", "prefetch hit done cycle", 32'(n), 2);
        store(la(9, 5), 32'h9595_0000, 1'b0);
        expect_wb(la(9, 5), 32'h9595_0000);
        issue(4'b1101, 3'b001, la(10, 5), n);
        q_empty("R8");
        expect_wb(la(7, 5), 32'h7575_0000);
        clean_all("R8");

        // R12 unsupported combination
        store(la(11, 11), 32'hBBBB_0011, 1'b0);
        issue(4'b0101, 3'b011, la(11, 11), n);
        chk(n == 1, "R12", "unsupported done cycle", 32'(n), 1);
        expect_wb(la(11, 11), 32'hBBBB_0011);
        clean_all("R12");

        // R9 drain write buffer
        wbuf_empty = 1'b0;
        send(4'b1010, 3'b100, 32'h0);
        repeat (5) @(negedge clk);
        chk(busy && !done, "R9", "busy while buffer not empty", {busy, done}, 2);
        wbuf_empty = 1'b1;
        wait_done(n);
        chk(done, "R9", "done after empty", 32'(done), 1);

        // R10 wait for interrupt, R11 ignore while busy
        store(la(12, 12), 32'hCCCC_0012, 1'b1);
        send(4'b0000, 3'b100, 32'h0);
        repeat (3) @(negedge clk);
        send(4'b1010, 3'b000, 32'h0);             // ignored clean-all
        store(la(13, 13), 32'hDDDD_0013, 1'b0);   // ignored store
        repeat (3) @(negedge clk);
        chk(busy && !done, "R10", "busy while no interrupt", {busy, done}, 2);
        irq = 1'b1;
        wait_done(n);
        irq = 1'b0;
        chk(done, "R10", "done after interrupt", 32'(done), 1);
        @(negedge clk);
        chk(!busy, "R11", "busy drops after done", 32'(busy), 0);
        expect_wb(la(12, 12), 32'hCCCC_0012);
        clean_all("R11");

        // R13 store and command in the same cycle
        @(negedge clk);
        st_en = 1'b1; st_addr = la(14, 14); st_data = 32'hEEEE_0014; st_way = 1'b1;
        cmd_valid = 1'b1; cmd_crm = 4'b1010; cmd_op2 = 3'b010;
        cmd_rd = 32'h8000_0000 | 32'(14 << 4);
        expect_wb(la(14, 14), 32'hEEEE_0014);
        @(negedge clk);
        st_en = 1'b0; cmd_valid = 1'b0;
        wait_done(n);
        q_empty("R13");

        // R2 run-time geometry
        issue(4'b0110, 3'b000, 32'h0, n);
        cfg_geom = G2;
        store(32'h0000_30C0, 32'h2222_0006, 1'b1);
        expect_wb(32'h0000_30C0, 32'h2222_0006);
        issue(4'b1010, 3'b010, 32'h8000_0000 | 32'(6 << 5) | 32'h1F, n);
        q_empty("R2");
        cfg_geom = G1;

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule